// File: doc/BRIEF.md
# Truncated Timestamp Seconds Extender

Packet event timestamps are stored in two 32-bit descriptor words. These words keep a full nanoseconds count but only the six least significant bits of the seconds count. This block rebuilds the full 48-bit seconds value from those bits and from the live seconds count of the time-of-day counter. It takes the missing upper bits from the live count. When the live count's low field has wrapped since the capture, it lowers those upper bits by one.

The rebuilt timestamp and its nanoseconds appear on registered outputs one clock after an input strobe. The outputs hold between strobes. The rebuild is correct only if the capture happened less than 64 seconds before the live reading. Reset is asynchronous and active-low, and its deassertion is expected to be synchronous to `clk`.

Top module: `ts_sec_extender`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_sec` is 0 and `out_nsec` is 0.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: After an accepted input, `out_nsec` equals bits [29:0] of `desc_w1` as sampled with `in_valid`.
- R4: The captured 6-bit seconds field is {`desc_w2`[3:0], `desc_w1`[31:30]}, with `desc_w2`[3] as its top bit. `out_sec`[5:0] equals this field. `desc_w2`[31:4] has no effect on any output.
- R5: If the field's top bit is 0, or bit 5 of `live_sec` is 1, then `out_sec` = (`live_sec` with bits [5:0] cleared) + field.
- R6: If the field's top bit is 1 and bit 5 of `live_sec` is 0, then `out_sec` = (`live_sec` with bits [5:0] cleared) + field − 64.
- R7: `out_sec` is taken modulo 2^48. In the R6 case with `live_sec` below 64, the result is 2^48 − 64 + field.
- R8: While `in_valid` is low, `out_sec` and `out_nsec` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: descriptor words and live seconds are valid |
| desc_w1 | input | 32 | Descriptor word holding nanoseconds and the low captured seconds bits |
| desc_w2 | input | 32 | Descriptor word holding the high captured seconds bits |
| live_sec | input | 48 | Current seconds count of the time-of-day counter |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_sec | output | 48 | Rebuilt full seconds of the packet event |
| out_nsec | output | 30 | Nanoseconds of the packet event |

## Verification
The wrap correction and the modulo-2^48 wraparound can both act on the same result. This happens when the captured top bit is set and the live seconds count is below 64: the decrement of the upper bits then borrows through all 42 of them. The bench provokes this by sweeping all 64 field values against all 64 low live values, with the upper live bits at zero, at all ones and at an arbitrary middle value. It judges every result against an expected value worked out as a 49-bit sum and difference, truncated to 48 bits.

// File: rtl/ts_ext_pkg.sv
package ts_ext_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned NS_W   = 30;
  parameter int unsigned LO_W   = 2;
  parameter int unsigned HI_W   = 4;
  parameter int unsigned SEC_W  = 48;
endpackage

// File: rtl/ts_field_split.sv
module ts_field_split #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NS_W   = 30,
  parameter int unsigned LO_W   = 2,
  parameter int unsigned HI_W   = 4,
  localparam int unsigned CAP_W = LO_W + HI_W
) (
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic [CAP_W-1:0]  cap_sec,
  output logic [NS_W-1:0]   cap_ns
);
  // low seconds bits sit directly above the nanoseconds field
  localparam int unsigned LO_MSB = NS_W + LO_W - 1;

  always_comb begin
    cap_ns  = word_a[NS_W-1:0];
    cap_sec = {word_b[HI_W-1:0], word_a[LO_MSB:NS_W]};
  end
endmodule

// File: rtl/ts_wrap_fix.sv
module ts_wrap_fix #(
  parameter int unsigned SEC_W = 48,
  parameter int unsigned CAP_W = 6,
  localparam int unsigned UP_W = SEC_W - CAP_W
) (
  input  logic [CAP_W-1:0] cap_sec,
  input  logic [SEC_W-1:0] live_sec,
  output logic [SEC_W-1:0] full_sec
);
  logic            wrapped;
  logic [UP_W-1:0] live_up;
  logic [UP_W-1:0] fixed_up;

  always_comb begin
    wrapped  = cap_sec[CAP_W-1] & ~live_sec[CAP_W-1];
    live_up  = live_sec[SEC_W-1:CAP_W];
    // subtracting one field period only touches the upper part
    fixed_up = live_up - {{(UP_W-1){1'b0}}, wrapped};
    full_sec = {fixed_up, cap_sec};
  end
endmodule

// File: rtl/ts_sec_extender.sv
module ts_sec_extender
  import ts_ext_pkg::*;
#(
  parameter int unsigned P_WORD_W = WORD_W,
  parameter int unsigned P_NS_W   = NS_W,
  parameter int unsigned P_LO_W   = LO_W,
  parameter int unsigned P_HI_W   = HI_W,
  parameter int unsigned P_SEC_W  = SEC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [P_WORD_W-1:0] desc_w1,
  input  logic [P_WORD_W-1:0] desc_w2,
  input  logic [P_SEC_W-1:0]  live_sec,
  output logic                out_valid,
  output logic [P_SEC_W-1:0]  out_sec,
  output logic [P_NS_W-1:0]   out_nsec
);
  localparam int unsigned CAP_W = P_LO_W + P_HI_W;

  logic [CAP_W-1:0]   cap_sec;
  logic [P_NS_W-1:0]  cap_ns;
  logic [P_SEC_W-1:0] full_sec;

  logic               valid_d;
  logic [P_SEC_W-1:0] sec_d;
  logic [P_NS_W-1:0]  nsec_d;

  ts_field_split #(
    .WORD_W(P_WORD_W), .NS_W(P_NS_W), .LO_W(P_LO_W), .HI_W(P_HI_W)
  ) u_split (
    .word_a (desc_w1),
    .word_b (desc_w2),
    .cap_sec(cap_sec),
    .cap_ns (cap_ns)
  );

  ts_wrap_fix #(
    .SEC_W(P_SEC_W), .CAP_W(CAP_W)
  ) u_fix (
    .cap_sec (cap_sec),
    .live_sec(live_sec),
    .full_sec(full_sec)
  );

  // next state: data loads only on the strobe
  always_comb begin
    valid_d = in_valid;
    sec_d   = out_sec;
    nsec_d  = out_nsec;
    if (in_valid) begin
      sec_d  = full_sec;
      nsec_d = cap_ns;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sec   <= '0;
      out_nsec  <= '0;
    end else begin
      out_valid <= valid_d;
      out_sec   <= sec_d;
      out_nsec  <= nsec_d;
    end
  end
endmodule

// File: rtl/ts_sec_extender_chk.sv
module ts_sec_extender_chk #(
  parameter int unsigned P_WORD_W = 32,
  parameter int unsigned P_NS_W   = 30,
  parameter int unsigned P_LO_W   = 2,
  parameter int unsigned P_HI_W   = 4,
  parameter int unsigned P_SEC_W  = 48,
  localparam int unsigned CAP_W = P_LO_W + P_HI_W,
  localparam int unsigned UP_W  = P_SEC_W - CAP_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [P_WORD_W-1:0] desc_w1,
  input logic [P_WORD_W-1:0] desc_w2,
  input logic [P_SEC_W-1:0]  live_sec,
  input logic                out_valid,
  input logic [P_SEC_W-1:0]  out_sec,
  input logic [P_NS_W-1:0]   out_nsec
);
  localparam int unsigned LO_MSB = P_NS_W + P_LO_W - 1;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  nsec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_nsec == $past(desc_w1[P_NS_W-1:0]));
  // R4
  low_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_sec[CAP_W-1:0] ==
      $past({desc_w2[P_HI_W-1:0], desc_w1[LO_MSB:P_NS_W]}));
  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(desc_w2[P_HI_W-1] && !live_sec[CAP_W-1]))
      |=> out_sec[P_SEC_W-1:CAP_W] == $past(live_sec[P_SEC_W-1:CAP_W]));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_w2[P_HI_W-1] && !live_sec[CAP_W-1])
      |=> out_sec[P_SEC_W-1:CAP_W] ==
          UP_W'($past(live_sec[P_SEC_W-1:CAP_W]) - UP_W'(1)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_sec) && $stable(out_nsec)));
endmodule

bind ts_sec_extender ts_sec_extender_chk #(
  .P_WORD_W(P_WORD_W), .P_NS_W(P_NS_W), .P_LO_W(P_LO_W),
  .P_HI_W(P_HI_W), .P_SEC_W(P_SEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .desc_w1(desc_w1), .desc_w2(desc_w2), .live_sec(live_sec),
  .out_valid(out_valid), .out_sec(out_sec), .out_nsec(out_nsec)
);

// File: tb/sim_ts_sec_extender.sv
module sim_ts_sec_extender;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] desc_w1;
  logic [31:0] desc_w2;
  logic [47:0] live_sec;
  logic        out_valid;
  logic [47:0] out_sec;
  logic [29:0] out_nsec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_sec_extender u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .desc_w1(desc_w1), .desc_w2(desc_w2), .live_sec(live_sec),
    .out_valid(out_valid), .out_sec(out_sec), .out_nsec(out_nsec)
  );

  function automatic logic [47:0] model_sec(input logic [5:0] cap, input logic [47:0] live);
    logic [48:0] acc;
    acc = {1'b0, live} - 49'(live % 64) + 49'(cap);
    if (cap >= 6'd32 && (live % 64) < 48'd32) acc = acc - 49'd64;
    return acc[47:0];
  endfunction

  task automatic check_out(input string req, input logic v_e,
                           input logic [47:0] s_e, input logic [29:0] n_e);
    n_chk++;
    if (out_valid !== v_e || out_sec !== s_e || out_nsec !== n_e) begin
      n_fail++;
      $display("FAIL %s: valid=%0b sec=%h nsec=%h expected valid=%0b sec=%h nsec=%h",
               req, out_valid, out_sec, out_nsec, v_e, s_e, n_e);
    end
  endtask

  // drive at a falling edge, result appears after the next rising edge
  task automatic drive(input logic [5:0] cap, input logic [29:0] ns,
                       input logic [27:0] junk, input logic [47:0] live);
    desc_w1  = {cap[1:0], ns};
    desc_w2  = {junk, cap[5:2]};
    live_sec = live;
    in_valid = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [47:0] uppers [3];
    logic [47:0] last_sec;
    logic [29:0] last_ns;
    uppers[0] = 48'h0;
    uppers[1] = 48'h1234_5678_9AC0;
    uppers[2] = 48'hFFFF_FFFF_FFC0;

    rst_n = 1'b0; in_valid = 1'b0;
    desc_w1 = '1; desc_w2 = '1; live_sec = '1;
    repeat (3) @(negedge clk);
    check_out("R1 reset", 1'b0, 48'h0, 30'h0);
    drive(6'd63, 30'h3FFF_FFFF, 28'hFFF_FFFF, 48'h5);
    @(negedge clk);
    check_out("R1 reset holds outputs", 1'b0, 48'h0, 30'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R2 idle after reset", 1'b0, 48'h0, 30'h0);

    // sweep: R3 R4 R5 R6 R7 with back-to-back strobes
    for (int u = 0; u < 3; u++) begin
      for (int c = 0; c < 64; c++) begin
        for (int l = 0; l < 64; l++) begin
          logic [29:0] ns;
          logic [27:0] junk;
          logic [47:0] live;
          string req;
          ns   = 30'((c * 7919 + l * 104729 + u * 999983) % (1 << 30));
          junk = 28'((c * 40503 + l * 2654435) ^ (u * 28'h5A5A5A5));
          live = uppers[u] | 48'(l);
          drive(6'(c), ns, junk, live);
          @(negedge clk);
          if (c >= 32 && l < 32)
            req = (u == 0) ? "R7 wrap below 64" : "R6 wrap";
          else
            req = "R5 no wrap";
          check_out({req, " R3 R4"}, 1'b1, model_sec(6'(c), live), ns);
        end
      end
    end

    // R8: strobe low, inputs change, outputs hold
    drive(6'd45, 30'h2AAA_5555, 28'h0, 48'hABCD_0000_0010);
    @(negedge clk);
    last_sec = model_sec(6'd45, 48'hABCD_0000_0010);
    last_ns  = 30'h2AAA_5555;
    check_out("R6 single strobe", 1'b1, last_sec, last_ns);
    in_valid = 1'b0;
    desc_w1 = 32'h1234_5678; desc_w2 = 32'h9;
    live_sec = 48'h7777_7777_7777;
    @(negedge clk);
    check_out("R2 R8 hold after drop", 1'b0, last_sec, last_ns);
    for (int k = 0; k < 8; k++) begin
      desc_w1 = 32'(k * 32'h1357_9BDF); desc_w2 = 32'(k);
      live_sec = 48'(k * 48'h11_2233_4455);
      @(negedge clk);
      check_out("R8 hold", 1'b0, last_sec, last_ns);
    end

    // R4: high word2 bits only differ -> same result
    drive(6'd17, 30'h1, 28'h0, 48'h100);
    @(negedge clk);
    check_out("R4 junk zero", 1'b1, model_sec(6'd17, 48'h100), 30'h1);
    drive(6'd17, 30'h1, 28'hFFF_FFFF, 48'h100);
    @(negedge clk);
    check_out("R4 junk ones", 1'b1, model_sec(6'd17, 48'h100), 30'h1);

    // R1: reset in mid-operation clears outputs
    in_valid = 1'b0;
    #(CLK_PERIOD/4) rst_n = 1'b0;
    @(negedge clk);
    check_out("R1 reset mid-run", 1'b0, 48'h0, 30'h0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule